// File: doc/BRIEF.md
# Memory Device Reset Sequencer

This block decides when the interface logic of a serial memory device may run. It handles two kinds of reset. A cold reset is qualified from a supply-low flag and a supply-valid flag. A warm reset is qualified from an active-low reset pin. While either reset is in progress, the block keeps the interface disabled and its data drivers off. When the reset completes, it raises a ready flag and the interface enters standby, where it can accept commands.

Every external flag passes through a two-flop synchronizer before it is used. Each timing rule is a down-counter. The counter is loaded with a parameter given in clock cycles, and it reports done when its final count runs out. All timing parameters must be at least 1.

The cold path works as follows. The supply-low flag must stay high for T_PD sampled cycles. After that, the supply must show valid while the low flag is clear, and a fixed power-up interval of T_PU cycles then runs. During that interval every input is ignored.

The warm path works as follows. The pin must stay low for T_RP cycles. Standby then returns only when both of these have happened:
- T_RPH cycles have passed since the warm reset began.
- T_RH cycles have passed since the pin went high again.

Cycle "k" below is the first clock edge that samples a changed input.

Top module: `mem_reset_seq`

## Requirements
- R1: A power-up begins only in the off state, and only after two things:
  - supply_low has been sampled high on T_PD consecutive edges;
  - supply_low is then sampled low while supply_ok is sampled high.
  
  If supply_low is held high for fewer edges, no power-up follows.
- R2: After qualification, let k be the edge where supply_low is low and supply_ok is high. Then ready rises after edge k+T_PU+2. During the power-up interval the block ignores supply_low and reset_n, so neither of them changes that edge.
- R3: The outputs ready, if_en and drive_en are high only in standby. They are low in every reset state and in the off state.
- R4: In standby, suppose reset_n is sampled low on edges k to k+L-1 with L >= T_RP. Then ready falls after edge k+T_RP+1. A low pulse with L < T_RP leaves ready high.
- R5: Let k be the first low edge of a warm reset and r the first edge with reset_n high again. Ready returns after edge max(k+T_RP+T_RPH+2, r+T_RH+2), and not earlier.
- R6: If supply_low qualifies during a warm reset, the warm reset is aborted and the block goes to the off state. This holds even when the qualification falls in the cycle in which the warm reset would end. Standby then returns only through a new power-up.
- R7: After rst_n the block is in the off state with all three outputs low. In the off state, reset_n has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| supply_low | input | 1 | Supply at or below its low level (asynchronous) |
| supply_ok | input | 1 | Supply at its valid level (asynchronous) |
| reset_n | input | 1 | Active-low warm reset pin (asynchronous) |
| if_en | output | 1 | Interface may respond to its inputs |
| drive_en | output | 1 | Interface may drive its data pins |
| ready | output | 1 | Interface is in standby and may accept commands |

## Verification
Two events can fall on the same clock edge: the supply-low qualification, and the warm-reset exit once both warm timers have expired. The abort scenario provokes this collision. It releases a four-cycle warm pulse and then raises supply_low so that its qualification lands exactly on the edge where standby would otherwise return. The result is judged by the ready flag:
- ready must stay low through that edge and through the whole new power-up;
- ready must rise only T_PU+2 cycles after the supply clears.

A separate check confirms the other ordering rule: a long supply-low run inside the power-up interval is ignored.

// File: rtl/mem_reset_seq.sv
module mem_reset_seq #(
  parameter int T_PD  = 8,
  parameter int T_PU  = 20,
  parameter int T_RP  = 4,
  parameter int T_RPH = 30,
  parameter int T_RH  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low,
  input  logic supply_ok,
  input  logic reset_n,
  output logic if_en,
  output logic drive_en,
  output logic ready
);
  localparam int WPD  = $clog2(T_PD + 1);
  localparam int WPU  = $clog2(T_PU + 1);
  localparam int WRP  = $clog2(T_RP + 1);
  localparam int WRPH = $clog2(T_RPH + 1);
  localparam int WRH  = $clog2(T_RH + 1);

  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_PU = 2'd1, ST_STBY = 2'd2, ST_WARM = 2'd3} st_t;
  st_t state;

  logic [2:0] sync1, sync2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= 3'b100;
      sync2 <= 3'b100;
    end else begin
      sync1 <= {reset_n, supply_ok, supply_low};
      sync2 <= sync1;
    end

  logic pin_s, ok_s, low_s;
  assign {pin_s, ok_s, low_s} = sync2;

  logic [WPD-1:0]  pd_cnt;
  logic [WPU-1:0]  pu_cnt;
  logic [WRP-1:0]  rp_cnt;
  logic [WRPH-1:0] rph_cnt;
  logic [WRH-1:0]  rh_cnt;
  logic            armed;

  wire qual    = (state != ST_PU) && low_s && (pd_cnt == WPD'(1));
  wire cold_go = (state == ST_OFF) && armed && ok_s && !low_s;
  wire warm_go = (state == ST_STBY) && !pin_s && (rp_cnt == WRP'(1));
  wire pu_done = (state == ST_PU) && (pu_cnt == WPU'(1));
  wire warm_ok = (rph_cnt == '0) && (rh_cnt == '0) && pin_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           pd_cnt <= WPD'(T_PD);
    else if (!low_s || state == ST_PU)    pd_cnt <= WPD'(T_PD);
    else if (pd_cnt != '0)                pd_cnt <= pd_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           rp_cnt <= WRP'(T_RP);
    else if (pin_s || state != ST_STBY)   rp_cnt <= WRP'(T_RP);
    else if (rp_cnt != '0)                rp_cnt <= rp_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           rh_cnt <= '0;
    else if (!pin_s)                      rh_cnt <= WRH'(T_RH);
    else if (rh_cnt != '0)                rh_cnt <= rh_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                    rph_cnt <= '0;
    else if (warm_go)                              rph_cnt <= WRPH'(T_RPH);
    else if (state == ST_WARM && rph_cnt != '0)    rph_cnt <= rph_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           pu_cnt <= '0;
    else if (cold_go)                     pu_cnt <= WPU'(T_PU);
    else if (state == ST_PU && pu_cnt != '0) pu_cnt <= pu_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 armed <= 1'b0;
    else if (state == ST_PU)    armed <= 1'b0;
    else if (qual)              armed <= 1'b1;
    else if (cold_go)           armed <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= ST_OFF;
    else if (state == ST_PU) begin
      if (pu_done) state <= ST_STBY;
    end else if (qual) state <= ST_OFF;
    else begin
      case (state)
        ST_OFF:  if (cold_go) state <= ST_PU;
        ST_STBY: if (warm_go) state <= ST_WARM;
        ST_WARM: if (warm_ok) state <= ST_STBY;
        default: state <= ST_OFF;
      endcase
    end

  assign ready    = (state == ST_STBY);
  assign if_en    = ready;
  assign drive_en = ready;
endmodule

module mem_reset_seq_chk #(
  parameter int T_PD  = 8,
  parameter int T_PU  = 20,
  parameter int T_RP  = 4,
  parameter int T_RPH = 30,
  parameter int T_RH  = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       pin_s,
  input logic       ready,
  input logic       if_en,
  input logic       drive_en
);
  localparam logic [1:0] OFF = 2'd0, PU = 2'd1, STBY = 2'd2, WARM = 2'd3;
  int unsigned pu_run, warm_run, hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pu_run <= 0; warm_run <= 0; hi_run <= 0; lo_run <= 0;
    end else begin
      pu_run   <= (state == PU)   ? ((pu_run   > T_PU)  ? pu_run   : pu_run + 1)   : 0;
      warm_run <= (state == WARM) ? ((warm_run > T_RPH) ? warm_run : warm_run + 1) : 0;
      hi_run   <= pin_s  ? ((hi_run > T_RH) ? hi_run : hi_run + 1) : 0;
      lo_run   <= !pin_s ? ((lo_run > T_RP) ? lo_run : lo_run + 1) : 0;
    end

  p_cold_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PU && $past(state) != PU) |-> $past(state) == OFF);
  p_pu_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == STBY && $past(state) == PU) |-> pu_run == T_PU);
  p_pu_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PU) |=> (state == PU || state == STBY));
  p_ready_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(state) == PU || $past(state) == WARM));
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != STBY) |-> (!drive_en && !if_en && !ready));
  p_warm_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WARM && $past(state) == STBY) |-> lo_run >= T_RP);
  p_warm_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == STBY && $past(state) == WARM) |-> (warm_run > T_RPH && hi_run > T_RH));
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == WARM && state != WARM && state != STBY) |-> state == OFF);
endmodule

bind mem_reset_seq mem_reset_seq_chk #(
  .T_PD(T_PD), .T_PU(T_PU), .T_RP(T_RP), .T_RPH(T_RPH), .T_RH(T_RH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .pin_s(pin_s),
  .ready(ready), .if_en(if_en), .drive_en(drive_en)
);

// File: tb/sim_mem_reset_seq.sv
module sim_mem_reset_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_PD = 8, T_PU = 20, T_RP = 4, T_RPH = 30, T_RH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_low = 1'b0, supply_ok = 1'b0, reset_n = 1'b1;
  logic if_en, drive_en, ready;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_reset_seq #(.T_PD(T_PD), .T_PU(T_PU), .T_RP(T_RP), .T_RPH(T_RPH), .T_RH(T_RH)) u0 (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .supply_ok(supply_ok),
    .reset_n(reset_n), .if_en(if_en), .drive_en(drive_en), .ready(ready));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic t_reset_r7();
    chk("R7", "ready after reset", ready, 1'b0);
    chk("R7", "if_en after reset", if_en, 1'b0);
    chk("R7", "drive_en after reset", drive_en, 1'b0);
  endtask

  task automatic t_short_cold_r1();
    for (int n = 0; n <= 40; n++) begin
      @(negedge clk);
      supply_low = (n < T_PD - 1);
      supply_ok  = (n >= T_PD - 1);
      reset_n    = !(n >= 20 && n < 30);
      @(posedge clk); #1;
      chk("R1", "short supply-low gives no power-up", ready, 1'b0);
      chk("R7", "pin ignored while off", if_en, 1'b0);
    end
  endtask

  task automatic t_cold_r2();
    for (int n = 0; n <= T_PU + T_PD + 2; n++) begin
      @(negedge clk);
      supply_low = (n < T_PD) || (n >= 12 && n < 24);
      supply_ok  = (n >= T_PD);
      reset_n    = !(n >= 12 && n < 24);
      @(posedge clk); #1;
      if (n == T_PD + T_PU + 1) chk("R2", "ready one cycle before end", ready, 1'b0);
      if (n == T_PD + 5) chk("R3", "drive_en off in power-up", drive_en, 1'b0);
      if (n == T_PD + T_PU + 2) begin
        chk("R2", "ready at power-up end", ready, 1'b1);
        chk("R3", "if_en in standby", if_en, 1'b1);
        chk("R3", "drive_en in standby", drive_en, 1'b1);
      end
    end
  endtask

  task automatic t_warm_r5(input int len, input int exit_at);
    for (int n = 0; n <= exit_at; n++) begin
      @(negedge clk);
      reset_n = !(n < len);
      @(posedge clk); #1;
      if (n == T_RP) chk("R4", "ready before warm entry", ready, 1'b1);
      if (n == T_RP + 1) begin
        chk("R4", "ready falls on warm entry", ready, 1'b0);
        chk("R3", "drive_en off in warm reset", drive_en, 1'b0);
      end
      if (n == exit_at - 1) chk("R5", "ready before both timers end", ready, 1'b0);
      if (n == exit_at) chk("R5", "ready after both timers end", ready, 1'b1);
    end
  endtask

  task automatic t_short_warm_r4();
    for (int n = 0; n <= 40; n++) begin
      @(negedge clk);
      reset_n = !(n < T_RP - 1);
      @(posedge clk); #1;
      chk("R4", "short pin pulse ignored", ready, 1'b1);
    end
  endtask

  task automatic t_abort_r6();
    int coll = T_RP + T_RPH + 2;
    int lo_start = coll - T_PD - 1;
    int lo_end = coll + 4;
    for (int n = 0; n <= lo_end + 2 + T_PU; n++) begin
      @(negedge clk);
      reset_n    = !(n < T_RP);
      supply_low = (n >= lo_start && n < lo_end);
      supply_ok  = 1'b1;
      @(posedge clk); #1;
      if (n > T_RP && n < lo_end + 2 + T_PU)
        chk("R6", "no standby after abort", ready, 1'b0);
      if (n == lo_end + 2 + T_PU) chk("R6", "standby after new power-up", ready, 1'b1);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1; t_reset_r7();
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_short_cold_r1();
        repeat (4) @(posedge clk);
        t_cold_r2();
        repeat (4) @(posedge clk);
        t_warm_r5(T_RP, T_RP + T_RPH + 2);
        repeat (4) @(posedge clk);
        t_warm_r5(50, 50 + T_RH + 2);
        repeat (4) @(posedge clk);
        t_short_warm_r4();
        repeat (4) @(posedge clk);
        t_abort_r6();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule